// File: doc/BRIEF.md
# LED Driver Fault Readback Shift Register

This block is the digital serial data path of a 16-channel LED sink driver. Serial data clocks into a shift register one bit per rising edge, most significant bit first. The bit at the register's top is driven on the serial output, so several drivers can be chained. A latch strobe copies the register into the output latch. The channel drive outputs show the latch contents while the active-low output enable is low, and are all off while it is high.

In special mode the output-enable line becomes a command. The block counts consecutive rising edges on which the enable is sampled low. The first two such edges freeze the register and switch its load source away from the serial input. The third edge and every later one load the per-channel fault vector into the register. Each channel has three fault inputs: open load, shorted output and overtemperature. These merge into a single bit for that channel, so readback cannot tell the fault types apart. A 0 marks a fault on a channel that is driven. A channel whose latch bit is off always reports 1.

Once the enable returns high, the register shifts again. The first 16 bits on the serial output are the captured fault vector, channel 15 first. Serial input data follows them. The enable may stay low for any number of cycles. The reset is asynchronous and active low, and its release is synchronized to the clock.

Top module: `ledrv_fault_readback`

## Requirements
- R1: While reset is asserted, and after it, the serial output is 0 and all 16 channel drive outputs are 0.
- R2: On each rising edge where the strobe is low and no special-mode capture sequence is active, the register shifts up by one. The serial input enters bit 0 and the serial output shows bit 15, so a word leaves with its bit 15 first.
- R3: An edge with the latch strobe high copies the register into the output latch. On that edge the register does not shift.
- R4: Channel drive output n equals latch bit n while the enable is low, and is 0 while the enable is high.
- R5: In special mode, the first and second consecutive edges with the enable low leave the register unchanged.
- R6: In special mode, the third and every later consecutive edge with the enable low loads the fault vector. Bit n of that vector is 0 when latch bit n is 1 and any fault input of channel n is 1. Otherwise bit n is 1.
- R7: Open, short and overtemperature faults each produce the same 0 in their channel's bit, and they cannot be told apart.
- R8: A channel whose latch bit is 0 reports 1, whatever its fault inputs show.
- R9: With fault inputs held steady, the captured vector is the same however long the enable stays low. After the enable goes high, the first 16 serial output bits are that vector, bit 15 first, and serial input data follows them.
- R10: In normal mode, an enable held low only drives the outputs. The register keeps shifting serial data and never loads the fault vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling is on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi_i | input | 1 | Serial data input |
| le_i | input | 1 | Latch strobe: copies the register into the output latch |
| oe_n_i | input | 1 | Active-low output enable; in special mode it also drives the capture sequence |
| special_i | input | 1 | 1 selects special mode, 0 selects normal mode |
| flt_open_i | input | 16 | Open-load flag for each channel |
| flt_short_i | input | 16 | Shorted-output flag for each channel |
| flt_temp_i | input | 16 | Overtemperature flag for each channel |
| sdo_o | output | 1 | Serial data output (register bit 15) |
| out_on_o | output | 16 | Channel drive outputs |

## Verification
The bench first runs exactly two low enable samples and then reads the register back. A design that captures one edge too early returns the fault vector here instead of the original data. It then holds the enable low for a random count of between 3 and 40 edges. A design that captures only once, or drops the vector on a long low phase, shows up here. The fault flags are drawn sparsely and separately for each type, and some land on channels that are switched off. This catches a merge that ignores a fault type or ignores the latch gating. Each readback is followed by a second 16-bit read to prove that serial data takes over behind the vector. Last, the enable is held low in normal mode, where a design that captures anyway returns fault bits instead of the shifted data.

// File: rtl/ledrv_pkg.sv
package ledrv_pkg;
  // Load source of the shift register for the current edge
  typedef enum logic [1:0] {
    SRC_SERIAL = 2'd0,
    SRC_HOLD   = 2'd1,
    SRC_FAULT  = 2'd2
  } src_sel_e;
endpackage

// File: rtl/ledrv_oe_seq.sv
module ledrv_oe_seq
  import ledrv_pkg::*;
#(
  parameter int CAPTURE_AT = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     special_i,
  input  logic     oe_n_i,
  output src_sel_e src_sel_o
);
  localparam int CW = $clog2(CAPTURE_AT + 1);
  localparam logic [CW-1:0] SAT = CW'(CAPTURE_AT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          seq_active;

  assign seq_active = special_i & ~oe_n_i;

  always_comb begin
    if (!seq_active)       cnt_d = '0;
    else if (cnt_q != SAT) cnt_d = cnt_q + 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_comb begin
    if (!seq_active)        src_sel_o = SRC_SERIAL;
    else if (cnt_q == SAT)  src_sel_o = SRC_FAULT;
    else                    src_sel_o = SRC_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ledrv_fault_merge.sv
module ledrv_fault_merge #(
  parameter int NCH = 16
) (
  input  logic [NCH-1:0] latch_i,
  input  logic [NCH-1:0] flt_open_i,
  input  logic [NCH-1:0] flt_short_i,
  input  logic [NCH-1:0] flt_temp_i,
  output logic [NCH-1:0] fault_vec_o
);
  for (genvar n = 0; n < NCH; n++) begin : g_ch
    // One status bit per channel; 0 = driven channel with any fault
    assign fault_vec_o[n] = latch_i[n]
                          ? ~(flt_open_i[n] | flt_short_i[n] | flt_temp_i[n])
                          : 1'b1;
  end
endmodule

// File: rtl/ledrv_shift_core.sv
module ledrv_shift_core
  import ledrv_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sdi_i,
  input  logic           le_i,
  input  src_sel_e       src_sel_i,
  input  logic [NCH-1:0] fault_vec_i,
  output logic [NCH-1:0] sr_q,
  output logic [NCH-1:0] latch_q
);
  logic [NCH-1:0] sr_d;
  logic           latch_en;

  always_comb begin
    unique case (src_sel_i)
      SRC_SERIAL: sr_d = le_i ? sr_q : {sr_q[NCH-2:0], sdi_i};
      SRC_HOLD:   sr_d = sr_q;
      SRC_FAULT:  sr_d = fault_vec_i;
      default:    sr_d = sr_q;
    endcase
  end

  assign latch_en = le_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (latch_en) latch_q <= sr_q;
  end
endmodule

// File: rtl/ledrv_fault_readback.sv
module ledrv_fault_readback
  import ledrv_pkg::*;
#(
  parameter int NCH        = 16,
  parameter int CAPTURE_AT = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sdi_i,
  input  logic           le_i,
  input  logic           oe_n_i,
  input  logic           special_i,
  input  logic [NCH-1:0] flt_open_i,
  input  logic [NCH-1:0] flt_short_i,
  input  logic [NCH-1:0] flt_temp_i,
  output logic           sdo_o,
  output logic [NCH-1:0] out_on_o
);
  logic           rst_meta_n, rst_sync_n;
  src_sel_e       src_sel;
  logic [NCH-1:0] sr_q, latch_q, fault_vec;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  ledrv_oe_seq #(.CAPTURE_AT(CAPTURE_AT)) seq_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .special_i (special_i),
    .oe_n_i    (oe_n_i),
    .src_sel_o (src_sel)
  );

  ledrv_fault_merge #(.NCH(NCH)) merge_i (
    .latch_i     (latch_q),
    .flt_open_i  (flt_open_i),
    .flt_short_i (flt_short_i),
    .flt_temp_i  (flt_temp_i),
    .fault_vec_o (fault_vec)
  );

  ledrv_shift_core #(.NCH(NCH)) core_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sdi_i       (sdi_i),
    .le_i        (le_i),
    .src_sel_i   (src_sel),
    .fault_vec_i (fault_vec),
    .sr_q        (sr_q),
    .latch_q     (latch_q)
  );

  assign sdo_o    = sr_q[NCH-1];
  assign out_on_o = latch_q & {NCH{~oe_n_i}};
endmodule

// File: rtl/ledrv_fault_readback_chk.sv
module ledrv_fault_readback_chk
  import ledrv_pkg::*;
#(
  parameter int NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sdi_i,
  input logic           le_i,
  input logic           oe_n_i,
  input logic           special_i,
  input src_sel_e       src_sel,
  input logic [NCH-1:0] sr_q,
  input logic [NCH-1:0] latch_q,
  input logic [NCH-1:0] fault_vec,
  input logic [NCH-1:0] out_on_o
);
  a_r4_dark_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> out_on_o == '0);

  a_r2_serial_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_SERIAL && !le_i) |=> sr_q == {$past(sr_q[NCH-2:0]), $past(sdi_i)});

  a_r3_latch_copy: assert property (@(posedge clk) disable iff (!rst_n)
    le_i |=> latch_q == $past(sr_q));

  a_r5_hold_early: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel == SRC_HOLD |=> $stable(sr_q));

  a_r6_fault_load: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel == SRC_FAULT |=> sr_q == $past(fault_vec));

  a_r8_off_reports_one: assert property (@(posedge clk) disable iff (!rst_n)
    ((~latch_q) & (~fault_vec)) == '0);

  a_r10_normal_never_loads: assert property (@(posedge clk) disable iff (!rst_n)
    !special_i |-> src_sel == SRC_SERIAL);
endmodule

bind ledrv_fault_readback ledrv_fault_readback_chk #(.NCH(NCH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .sdi_i     (sdi_i),
  .le_i      (le_i),
  .oe_n_i    (oe_n_i),
  .special_i (special_i),
  .src_sel   (src_sel),
  .sr_q      (sr_q),
  .latch_q   (latch_q),
  .fault_vec (fault_vec),
  .out_on_o  (out_on_o)
);

// File: tb/ledrv_fault_readback_tb.sv
module ledrv_fault_readback_tb_top;
  localparam int NCH = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           sdi = 1'b0, le = 1'b0, oe_n = 1'b1, special = 1'b0;
  logic [NCH-1:0] f_open = '0, f_short = '0, f_temp = '0;
  logic           sdo;
  logic [NCH-1:0] out_on;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ledrv_fault_readback #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .sdi_i(sdi), .le_i(le), .oe_n_i(oe_n),
    .special_i(special), .flt_open_i(f_open), .flt_short_i(f_short),
    .flt_temp_i(f_temp), .sdo_o(sdo), .out_on_o(out_on)
  );

  function automatic logic [NCH-1:0] exp_fault(input logic [NCH-1:0] lat,
      input logic [NCH-1:0] o, input logic [NCH-1:0] s, input logic [NCH-1:0] t);
    return ~(lat & (o | s | t));
  endfunction

  task automatic check(input string req, input logic [NCH-1:0] got,
                       input logic [NCH-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic shift_in(input logic [NCH-1:0] p);
    for (int i = 0; i < NCH; i++) begin
      sdi = p[NCH-1-i];
      step();
    end
  endtask

  task automatic latch_pulse();
    le = 1'b1; sdi = ~sdi;
    step();
    le = 1'b0;
  endtask

  task automatic read_out(input logic [NCH-1:0] fill, output logic [NCH-1:0] v);
    for (int i = 0; i < NCH; i++) begin
      v[NCH-1-i] = sdo;
      sdi = fill[NCH-1-i];
      step();
    end
  endtask

  task automatic low_phase(input int k);
    special = 1'b1; oe_n = 1'b0;
    repeat (k) step();
    oe_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [NCH-1:0] p, q, fill, v, exp;
    int k;
    void'($urandom(32'd1234));
    #23;
    check("R1 reset sdo", NCH'(sdo), '0);
    check("R1 reset outputs", out_on, '0);
    rst_n = 1'b1;
    repeat (3) step();
    check("R1 after reset outputs", out_on, '0);

    // R2 + R3 + R4: shift, latch, drive gating
    p = 16'hA5C3;
    shift_in(p);
    check("R2 msb on sdo", NCH'(sdo), NCH'(p[NCH-1]));
    latch_pulse();
    check("R4 disabled outputs off", out_on, '0);
    oe_n = 1'b0; #1;
    check("R4 enabled outputs follow latch", out_on, p);
    oe_n = 1'b1;
    read_out(16'h1234, v);
    check("R3 register held on strobe, R2 order", v, p);

    // R5: two low samples do nothing
    shift_in(16'h0F0F);
    f_open = 16'hFFFF;
    low_phase(2);
    special = 1'b0;
    read_out(16'h0, v);
    check("R5 two low edges keep register", v, 16'h0F0F);
    f_open = '0;

    // R7 + R8: directed merge, latch = A5C3
    shift_in(16'hA5C3); latch_pulse();
    f_open = 16'h0001; f_short = 16'h0040; f_temp = 16'h8000;
    low_phase(3);
    read_out(16'h0, v);
    special = 1'b0;
    check("R7 each fault type gives 0", v, 16'h7FBE);
    f_open = 16'h0004; f_short = 16'h0008; f_temp = 16'h0010;
    low_phase(5);
    read_out(16'h0, v);
    special = 1'b0;
    check("R8 off channels report 1", v, 16'hFFFF);
    f_open = '0; f_short = '0; f_temp = '0;

    // R6 + R9: random capture lengths and faults
    for (int it = 0; it < 24; it++) begin
      p = NCH'($urandom);
      fill = NCH'($urandom);
      k = 3 + int'($urandom % 38);
      shift_in(p); latch_pulse();
      f_open  = NCH'($urandom & $urandom & $urandom);
      f_short = NCH'($urandom & $urandom & $urandom);
      f_temp  = NCH'($urandom & $urandom & $urandom);
      exp = exp_fault(p, f_open, f_short, f_temp);
      special = 1'b1; oe_n = 1'b0;
      repeat (k) step();
      check("R4 outputs on during detection", out_on, p);
      oe_n = 1'b1;
      read_out(fill, v);
      check(k == 3 ? "R6 capture on third edge" : "R9 long low capture", v, exp);
      read_out(16'h0, v);
      check("R9 serial data follows vector", v, fill);
      special = 1'b0;
    end

    // R10: normal mode with enable low keeps shifting
    f_open = 16'hFFFF;
    shift_in(16'hFFFF); latch_pulse();
    oe_n = 1'b0;
    q = 16'h3C96;
    shift_in(q);
    repeat (0) step();
    read_out(16'h0, v);
    check("R10 normal mode no capture", v, q);
    check("R4 outputs still latch in normal", out_on, 16'hFFFF);
    oe_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule